// File: doc/BRIEF.md
# Configuration Stream Header and Frame Parser

This block takes in a device configuration load and turns it into checked frames. Two stream layouts are accepted. In serial mode one bit arrives per accepted clock. In byte-wide express mode a whole byte arrives per accepted clock, and its eight bits are taken in order from bit 0 to bit 7. Both layouts share one bit-level grammar.

The header opens with a run of ones, followed by a 4-bit preamble. In serial mode a 24-bit length count and a separator come next. In express mode 24 fill bits stand in their place. A fixed number of frames then follows. Each frame has a start bit, the frame data, and a 4-bit check field. Serial loads close with a 4-bit postamble.

Once the data has ended, the block counts a few further start-up inputs and then raises `done`. A checksum failure or a bad start bit sets a sticky error. That error suppresses any further frame output and keeps `done` low until reset. A wrong length count or a wrong postamble sets its own sticky flag.

Top module: `cfg_stream_parser`

## Requirements
- R1: Header search needs eight consecutive ones followed by the preamble `PRE_CODE` (default 4'b0010), taken most significant bit first. Further ones after the eighth are absorbed. A zero before the eighth one restarts the search. A preamble bit that does not match also restarts the search, and a mismatching bit equal to 1 counts as the first one of the new run.
- R2: After the preamble, serial mode reads a 24-bit length count (most significant bit first) and then `SEP_BITS` separator bits, whose values are ignored. Express mode instead reads 24 fill bits whose values are ignored, and has no separator.
- R3: Each frame is one start bit, then `FRAME_BITS` data bits, then 4 check bits. The first data bit received lands in the most significant bit of `frame_data`. `frame_vld` pulses for one cycle, together with `frame_data`, starting on the clock edge that accepts the last check bit of the frame. Exactly `NUM_FRAMES` frames are produced per load.
- R4: Check bit k (k = 0..3, received in that order) must equal the XOR of the data bits whose arrival index (0-based) modulo 4 is k. In serial mode, a check mismatch sets the sticky `frame_err`. A start bit of 1 sets `frame_err` in either mode. While `frame_err` is set, `frame_vld` stays low and `done` never rises.
- R5: In express mode the check field is ignored: a wrong check field neither drops the frame nor sets `frame_err`.
- R6: In serial mode the postamble `POST_CODE` (default 4'b0111, most significant bit first) follows the last frame. `len_err` is set when the postamble is wrong. It is also set when the length count differs from the number of bits counted from the first frame start bit through the last postamble bit, which is NUM_FRAMES*(FRAME_BITS+5)+4. Express mode never sets `len_err`.
- R7: End of data is the last postamble bit in serial mode and the last check bit in express mode. `done` rises on the edge that accepts the `STARTUP_CLKS`-th accepted input after the one that ends the data. Start-up values are don't-care, and `done` then stays high until reset.
- R8: In express mode, bit 0 of each byte is processed first and bit 7 last. Bits of the final byte that follow the end of data are don't-care.
- R9: Driving `cs` low at any time before `done` aborts the load. The parser returns to header search, and a complete load supplied afterwards succeeds. Driving `cs` low after `done` has no effect.
- R10: After reset, `frame_vld`, `frame_data`, `frame_err`, `len_err` and `done` are all 0.
- R11: Cycles with `in_vld` low do not advance the parser, whatever values are on the data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_exp | input | 1 | 0 = serial bit mode, 1 = byte-wide express mode |
| cs | input | 1 | Chip select; low before done aborts the load |
| in_vld | input | 1 | Input data valid strobe |
| bit_in | input | 1 | Serial data bit |
| byte_in | input | 8 | Express data byte, bit 0 first |
| frame_data | output | FRAME_BITS | Data of the most recent good frame |
| frame_vld | output | 1 | One-cycle frame valid pulse |
| frame_err | output | 1 | Sticky frame error |
| len_err | output | 1 | Sticky length count or postamble error |
| done | output | 1 | Configuration complete |

## Verification
All results are registered on the edge that accepts the deciding input: the last check bit for `frame_vld` and `frame_err`, the last postamble bit for `len_err`, and the final start-up input for `done`. The bench drives inputs on falling edges and reads results on the following falling edge, half a cycle after the capturing edge. A monitor records every `frame_vld` pulse at falling edges, so the frame count and frame words are compared after the load. `done` is read after the third start-up input, where it must be low, and again after the fourth.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int LANES    = 8;
  localparam int HDR_ONES = 8;
  localparam int CHK_W    = 4;

  typedef enum logic [3:0] {
    PH_HUNT, PH_PRE, PH_LEN, PH_SEP, PH_FSTART,
    PH_FDATA, PH_FCHK, PH_POST, PH_END
  } cfg_phase_e;
endpackage

// File: rtl/cfg_lane_sel.sv
module cfg_lane_sel #(
  parameter int LANES = 8
) (
  input  logic             mode_exp,
  input  logic             bit_in,
  input  logic [LANES-1:0] byte_in,
  output logic [LANES-1:0] lane_bit,
  output logic [LANES-1:0] lane_en
);
  // lane 0 is processed first: serial bit or byte bit 0 (R8)
  assign lane_bit[0] = mode_exp ? byte_in[0] : bit_in;
  assign lane_en[0]  = 1'b1;
  for (genvar i = 1; i < LANES; i++) begin : g_lane
    assign lane_bit[i] = byte_in[i];
    assign lane_en[i]  = mode_exp;
  end
endmodule

// File: rtl/cfg_startup_timer.sv
module cfg_startup_timer #(
  parameter int STARTUP_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic arm,
  input  logic tick,
  input  logic block,
  output logic done
);
  localparam int SW = (STARTUP_CLKS > 1) ? $clog2(STARTUP_CLKS) : 1;

  logic          armed;
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || (clear && !done)) begin
      armed <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (arm) begin
      armed <= 1'b1;
    end else if (armed && tick && !done) begin
      if (cnt == SW'(STARTUP_CLKS - 1)) done <= !block;
      else                              cnt  <= cnt + 1'b1;
    end
  end

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R7
  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(tick && armed)); // R7
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfg_stream_pkg::*;
#(
  parameter int         FRAME_BITS   = 64,
  parameter int         NUM_FRAMES   = 8,
  parameter int         LEN_W        = 24,
  parameter int         SEP_BITS     = 4,
  parameter int         STARTUP_CLKS = 4,
  parameter logic [3:0] PRE_CODE     = 4'b0010,
  parameter logic [3:0] POST_CODE    = 4'b0111
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_exp,
  input  logic                  cs,
  input  logic                  in_vld,
  input  logic                  bit_in,
  input  logic [7:0]            byte_in,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  frame_vld,
  output logic                  frame_err,
  output logic                  len_err,
  output logic                  done
);
  localparam int FB = FRAME_BITS;
  localparam int MX = (FB > LEN_W) ? FB : LEN_W;
  localparam int CW = $clog2(MX + 1);
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

  typedef struct packed {
    cfg_phase_e       ph;
    logic [3:0]       ones;
    logic [CW-1:0]    cnt;
    logic [FW-1:0]    frm;
    logic [FB-1:0]    sh;
    logic [CHK_W-1:0] chk;
    logic [CHK_W-1:0] rx;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] bits;
    logic             pmis;
  } pst_t;

  pst_t             cur, nx;
  logic [LANES-1:0] lane_bit, lane_en;
  logic             emit, ferr_ev, lerr_ev, end_ev;
  logic [FB-1:0]    word;

  cfg_lane_sel #(.LANES(LANES)) u_lanes (
    .mode_exp(mode_exp), .bit_in(bit_in), .byte_in(byte_in),
    .lane_bit(lane_bit), .lane_en(lane_en)
  );

  // one bit-step per lane, chained within the cycle
  always_comb begin
    logic             b;
    logic [CHK_W-1:0] rxf;
    logic             pm;
    nx = cur; emit = 1'b0; word = '0;
    ferr_ev = 1'b0; lerr_ev = 1'b0; end_ev = 1'b0;
    b = 1'b0; rxf = '0; pm = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) begin
        b = lane_bit[i];
        unique case (nx.ph)
          PH_HUNT: begin
            if (b) begin
              if (nx.ones != 4'(HDR_ONES)) nx.ones = nx.ones + 4'd1;
            end else if (nx.ones == 4'(HDR_ONES) && (b == PRE_CODE[3])) begin
              nx.ph = PH_PRE; nx.cnt = CW'(1);
            end else begin
              nx.ones = '0;
            end
          end
          PH_PRE: begin
            if (b == PRE_CODE[2'd3 - nx.cnt[1:0]]) begin
              if (nx.cnt == CW'(3)) begin nx.ph = PH_LEN; nx.cnt = '0; end
              else nx.cnt = nx.cnt + 1'b1;
            end else begin
              nx.ph = PH_HUNT; nx.cnt = '0; nx.ones = {3'b000, b};
            end
          end
          PH_LEN: begin
            if (!mode_exp) nx.len = {nx.len[LEN_W-2:0], b};
            if (nx.cnt == CW'(LEN_W - 1)) begin
              nx.cnt = '0; nx.bits = '0; nx.frm = '0;
              nx.ph = mode_exp ? PH_FSTART : PH_SEP;
            end else nx.cnt = nx.cnt + 1'b1;
          end
          PH_SEP: begin
            if (nx.cnt == CW'(SEP_BITS - 1)) begin nx.cnt = '0; nx.ph = PH_FSTART; end
            else nx.cnt = nx.cnt + 1'b1;
          end
          PH_FSTART: begin
            nx.bits = nx.bits + 1'b1;
            if (b) ferr_ev = 1'b1;
            nx.ph = PH_FDATA; nx.cnt = '0; nx.chk = '0;
          end
          PH_FDATA: begin
            nx.bits = nx.bits + 1'b1;
            nx.sh   = {nx.sh[FB-2:0], b};
            nx.chk[nx.cnt[1:0]] = nx.chk[nx.cnt[1:0]] ^ b;
            if (nx.cnt == CW'(FB - 1)) begin nx.cnt = '0; nx.rx = '0; nx.ph = PH_FCHK; end
            else nx.cnt = nx.cnt + 1'b1;
          end
          PH_FCHK: begin
            nx.bits = nx.bits + 1'b1;
            rxf = nx.rx;
            rxf[nx.cnt[1:0]] = b;
            nx.rx = rxf;
            if (nx.cnt == CW'(CHK_W - 1)) begin
              if (!mode_exp && (rxf != nx.chk)) ferr_ev = 1'b1;
              if (!ferr_ev) begin emit = 1'b1; word = nx.sh; end
              nx.cnt = '0;
              if (nx.frm == FW'(NUM_FRAMES - 1)) begin
                nx.pmis = 1'b0;
                if (mode_exp) begin nx.ph = PH_END; end_ev = 1'b1; end
                else nx.ph = PH_POST;
              end else begin
                nx.frm = nx.frm + 1'b1; nx.ph = PH_FSTART;
              end
            end else nx.cnt = nx.cnt + 1'b1;
          end
          PH_POST: begin
            nx.bits = nx.bits + 1'b1;
            pm = nx.pmis | (b != POST_CODE[2'd3 - nx.cnt[1:0]]);
            nx.pmis = pm;
            if (nx.cnt == CW'(3)) begin
              if (pm || (nx.bits != nx.len)) lerr_ev = 1'b1;
              nx.ph = PH_END; end_ev = 1'b1;
            end else nx.cnt = nx.cnt + 1'b1;
          end
          PH_END: ;
          default: nx.ph = PH_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur        <= '0;
      frame_data <= '0;
      frame_vld  <= 1'b0;
      frame_err  <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (!cs && !done) begin
        cur <= '0;
      end else if (in_vld && cs) begin
        cur <= nx;
        if (emit && !frame_err) begin
          frame_vld  <= 1'b1;
          frame_data <= word;
        end
        if (ferr_ev) frame_err <= 1'b1;
        if (lerr_ev) len_err   <= 1'b1;
      end
    end
  end

  cfg_startup_timer #(.STARTUP_CLKS(STARTUP_CLKS)) u_startup (
    .clk(clk), .rst(rst), .clear(!cs), .arm(in_vld && cs && end_ev),
    .tick(in_vld && cs), .block(frame_err), .done(done)
  );

  AST_NO_FRAME_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    (frame_err && $past(frame_err)) |-> !frame_vld); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err); // R4
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    done |-> !frame_err); // R4
  AST_VLD_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> $past(in_vld && cs)); // R3
  AST_LEN_SERIAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(len_err) |-> !$past(mode_exp)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && cs && !done) |=> (cur == $past(cur))); // R11
endmodule

// File: tb/tb_cfg_stream_parser.sv
module tb_cfg_stream_parser;
  localparam int FB = 8, NF = 3, SU = 4, LW = 24, SEPB = 4;
  localparam logic [3:0] PRE = 4'b0010, POST = 4'b0111;
  localparam int LCOUNT = NF * (FB + 5) + 4;

  logic clk = 0, rst = 1, mode_exp = 0, cs = 0, in_vld = 0, bit_in = 0;
  logic [7:0] byte_in = '0;
  logic [FB-1:0] frame_data;
  logic frame_vld, frame_err, len_err, done;

  cfg_stream_parser #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .LEN_W(LW),
    .SEP_BITS(SEPB), .STARTUP_CLKS(SU), .PRE_CODE(PRE), .POST_CODE(POST)) dut (
    .clk(clk), .rst(rst), .mode_exp(mode_exp), .cs(cs), .in_vld(in_vld),
    .bit_in(bit_in), .byte_in(byte_in), .frame_data(frame_data),
    .frame_vld(frame_vld), .frame_err(frame_err), .len_err(len_err), .done(done));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  int rx_n = 0;
  logic [FB-1:0] rx_w [0:15];
  logic sb [0:1023];
  int sn;

  always @(negedge clk) if (frame_vld === 1'b1) begin
    if (rx_n < 16) rx_w[rx_n] = frame_data;
    rx_n++;
  end

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] wordf(input int seed, input int f);
    return FB'((seed * 3 + f) % 256);
  endfunction

  task automatic pushb(input logic b);
    sb[sn] = b; sn++;
  endtask

  task automatic build(input bit ex, input int seed, input int flt);
    logic [FB-1:0] w; logic [3:0] c; logic [LW-1:0] l;
    sn = 0;
    if (flt == 5) begin for (int i = 0; i < 7; i++) pushb(1); pushb(0); end
    if (flt == 6) begin for (int i = 0; i < 8; i++) pushb(1); pushb(0); pushb(0); pushb(1); pushb(1); end
    for (int i = 0; i < 8; i++) pushb(1);
    for (int i = 3; i >= 0; i--) pushb(PRE[i]);
    if (!ex) begin
      l = LW'(LCOUNT + ((flt == 2) ? 1 : 0));
      for (int i = LW - 1; i >= 0; i--) pushb(l[i]);
      for (int i = 0; i < SEPB; i++) pushb(i % 2);
    end else begin
      for (int i = 0; i < LW; i++) pushb((i + seed) % 3 == 0);
    end
    for (int f = 0; f < NF; f++) begin
      w = wordf(seed, f); c = '0;
      for (int i = 0; i < FB; i++) c[i % 4] = c[i % 4] ^ w[FB - 1 - i];
      if (flt == 1 && f == 1) c[0] = ~c[0];
      pushb((flt == 4 && f == 2) ? 1'b1 : 1'b0);
      for (int i = FB - 1; i >= 0; i--) pushb(w[i]);
      for (int k = 0; k < 4; k++) pushb(c[k]);
    end
    if (!ex) for (int i = 3; i >= 0; i--) pushb((flt == 3 && i == 0) ? ~POST[i] : POST[i]);
  endtask

  task automatic drv(input logic b, input logic [7:0] by, input bit g);
    @(negedge clk); bit_in = b; byte_in = by; in_vld = 1; cs = 1;
    if (g) begin @(negedge clk); in_vld = 0; bit_in = ~b; byte_in = ~by; end
  endtask

  task automatic send(input bit ex, input bit g);
    logic [7:0] by;
    if (!ex) for (int i = 0; i < sn; i++) drv(sb[i], 8'h00, g);
    else for (int k = 0; k < (sn + 7) / 8; k++) begin
      for (int j = 0; j < 8; j++) by[j] = (8 * k + j < sn) ? sb[8 * k + j] : 1'b1;
      drv(1'b0, by, g);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; cs = 0; in_vld = 0;
    repeat (2) @(negedge clk);
    rst = 0; rx_n = 0;
  endtask

  task automatic startup(input int seed, input bit g, input int exp_done, input string tg);
    for (int i = 0; i < SU - 1; i++) drv(1'(seed + i), 8'(seed * 7 + i), g);
    @(negedge clk); in_vld = 0;
    chk({tg, " R7 done early"}, done, 0);
    drv(1'(seed), 8'(seed), g);
    @(negedge clk); in_vld = 0;
    chk({tg, " R7 done"}, done, exp_done);
  endtask

  task automatic run(input bit ex, input int seed, input int flt, input bit g, input string tg);
    int en, ee, el, ed;
    en = NF; ee = 0; el = 0; ed = 1;
    if (flt == 1 && !ex) begin en = 1; ee = 1; ed = 0; end
    if ((flt == 2 || flt == 3) && !ex) el = 1;
    if (flt == 4) begin en = 2; ee = 1; ed = 0; end
    do_reset();
    mode_exp = ex;
    build(ex, seed, flt);
    send(ex, g);
    startup(seed, g, ed, tg);
    chk({tg, " R3 frame count"}, rx_n, en);
    for (int f = 0; f < en && f < 16; f++) chk({tg, ex ? " R8 word" : " R3 word"}, rx_w[f], wordf(seed, f));
    chk({tg, ex ? " R5 frame_err" : " R4 frame_err"}, frame_err, ee);
    chk({tg, " R6 len_err"}, len_err, el);
  endtask

  initial begin
    #(20 * 190000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R10 frame_vld", frame_vld, 0);
    chk("R10 frame_data", frame_data, 0);
    chk("R10 frame_err", frame_err, 0);
    chk("R10 len_err", len_err, 0);
    chk("R10 done", done, 0);
    // exhaustive sweep of frame words, both modes (R2 fill/separator ignored)
    for (int s = 0; s < 86; s++) begin
      run(0, s, 0, 0, "R2 serial");
      run(1, s, 0, 0, "R2 express");
    end
    run(0, 11, 1, 0, "R4 bad check");
    run(1, 11, 1, 0, "R5 check ignored");
    run(0, 12, 2, 0, "R6 length");
    run(1, 12, 2, 0, "R6 express length");
    run(0, 13, 3, 0, "R6 postamble");
    run(0, 14, 4, 0, "R4 start bit serial");
    run(1, 14, 4, 0, "R4 start bit express");
    run(0, 15, 5, 0, "R1 early zero");
    run(1, 15, 5, 0, "R1 early zero express");
    run(0, 16, 6, 0, "R1 preamble miss");
    run(1, 16, 6, 0, "R1 preamble miss express");
    run(0, 17, 0, 1, "R11 gaps serial");
    run(1, 18, 0, 1, "R11 gaps express");
    // R9 abort mid-frame then a full load
    do_reset();
    mode_exp = 0;
    build(0, 20, 0);
    for (int i = 0; i < 50; i++) drv(sb[i], 8'h00, 0);
    @(negedge clk); cs = 0; in_vld = 0;
    @(negedge clk);
    send(0, 0);
    startup(20, 0, 1, "R9 after abort");
    chk("R9 frame count", rx_n, NF);
    for (int f = 0; f < NF; f++) chk("R9 word", rx_w[f], wordf(20, f));
    @(negedge clk); cs = 0;
    repeat (3) @(negedge clk);
    chk("R9 cs low after done", done, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule